// File: doc/BRIEF.md
# Link Receiver Output State Controller

This block sits between the word recovery of a serial link receiver and its parallel output pins. Each recovered 21-bit word arrives with a strobe and a frame-check error flag. The block decides whether the link is locked from the run of good and bad frames and from the clock-recovery lock indication. It presents words on the parallel bus only while locked. While unlocked, the data and clock pins rest in a sleep state picked by a control bit: either high-impedance or driven low.

The output clock is modelled as a source select. It carries the recovered pixel clock while locked. While unlocked, it can fall back to the internal oscillator if the auto-clock bit allows it and the oscillator is running. The edge-select bit tells the pin logic which clock edge the data changes on. In auto power-down mode, a serial stream that stays absent for a set number of cycles sends the block into power-down. When the stream returns, the block reacquires lock by itself. The power-down input forces the unlocked, powered-down state at any time.

The input stream uses valid/ready. `in_ready` is high whenever the block is not powered down, and the block never applies back-pressure while powered. Words offered while `in_ready` is low are dropped. The output stream has no ready: `out_valid` pulses for one cycle per presented word, and the consumer must take it then.

Top module: `link_rx_out_ctrl`

## Requirements
- R1: When `pwr_en` is low at a clock edge, the block is powered down after that edge: `lock_o` is 0, `in_ready` is 0, and the outputs are in the selected sleep state.
- R2: From the acquiring state, `lock_o` rises after 16 consecutive accepted good frames (`in_valid`=1, `in_err`=0, `cdr_lock`=1). A bad frame, or `cdr_lock` low, restarts the count.
- R3: While locked, lock is lost after `cfg_loss_lim` consecutive bad frames (`in_err`=1), with a limit of 0 treated as 1. A good frame in between clears the run.
- R4: While locked, `cdr_lock` low at a clock edge drops `lock_o` after that edge.
- R5: While unlocked with `cfg_sleep_low`=0, every bit of `out_oe` is 0 and `out_data` is 0. `clk_oe` is 0 unless the oscillator fallback of R7 is active.
- R6: While unlocked with `cfg_sleep_low`=1, every bit of `out_oe` is 1, `out_data` is 0 and `clk_oe` is 1. With no oscillator fallback, `clk_sel` is 2'b00, so the clock pin is held low.
- R7: `clk_sel` is 2'b01 (recovered pixel clock) while locked. While unlocked it is 2'b10 (internal oscillator) when both `cfg_auto_clk` and `osc_en` are 1, and 2'b00 (no clock) otherwise. `clk_oe` is 1 while the clock is the pixel clock or the oscillator.
- R8: `out_edge_rise` follows `cfg_edge_rise` one edge later while unlocked. While locked it holds the value captured when lock was acquired.
- R9: The frame whose acceptance raises `lock_o` is not presented. A frame accepted while `lock_o` is already high appears on `out_data` after its capture edge, with `out_valid` high for exactly that one cycle.
- R10: With `cfg_auto_pd`=1, `sig_det` low for `IDLE_CYCLES` consecutive edges powers the block down (`lock_o`=0, `in_ready`=0). Frames offered during power-down are ignored. Once `sig_det` is high, `in_ready` returns after one edge, and 16 good frames relock the link.
- R11: With `cfg_auto_pd`=0, `sig_det` has no effect: a locked link stays locked however long `sig_det` is low.
- R12: `in_ready` is 1 in the acquiring and locked states, so accepted frames are never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (one tick per recovered word slot) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Power enable; low forces power-down |
| in_data | input | DATA_W | Recovered parallel word |
| in_valid | input | 1 | Recovered word strobe |
| in_err | input | 1 | Frame-check failure for the offered word |
| in_ready | output | 1 | Block accepts words (not powered down) |
| cdr_lock | input | 1 | Clock-recovery lock indication |
| sig_det | input | 1 | Serial stream present |
| osc_en | input | 1 | Internal oscillator running |
| cfg_sleep_low | input | 1 | Sleep state: 0 high-impedance, 1 driven low |
| cfg_auto_clk | input | 1 | Allow oscillator clock while unlocked |
| cfg_edge_rise | input | 1 | Data changes on rising (1) or falling (0) clock edge |
| cfg_auto_pd | input | 1 | Enable auto power-down on stream loss |
| cfg_loss_lim | input | LOSS_W | Consecutive bad frames that end lock |
| out_data | output | DATA_W | Parallel output word |
| out_valid | output | 1 | One-cycle pulse per presented word |
| out_oe | output | DATA_W | Per-bit data output enable |
| clk_sel | output | 2 | Output clock source: 00 none, 01 pixel, 10 oscillator |
| clk_oe | output | 1 | Output clock pin enable |
| out_edge_rise | output | 1 | Active edge select applied to the pins |
| lock_o | output | 1 | Link locked and outputs active |

## Verification
The assertions assume that `cdr_lock`, `sig_det`, `pwr_en` and the control bits are synchronous to `clk`. They also assume that a frame is signalled only by `in_valid`, so that `in_err` matters only while it is high. The stimulus changes every input at the falling clock edge, so each input is stable across the rising edge that samples it. The control bits change only between scenarios or at points where the test means to observe their effect. The bench presents words only when it intends them to count toward acquisition, loss or output.

// File: rtl/lro_pkg.sv
package lro_pkg;
  typedef enum logic [1:0] {
    LS_PD   = 2'd0,
    LS_ACQ  = 2'd1,
    LS_LOCK = 2'd2
  } link_state_t;

  typedef enum logic [1:0] {
    CK_OFF   = 2'b00,
    CK_PIXEL = 2'b01,
    CK_OSC   = 2'b10
  } clk_src_t;
endpackage

// File: rtl/lro_lock_fsm.sv
module lro_lock_fsm
  import lro_pkg::*;
#(
  parameter int ACQ_FRAMES  = 16,
  parameter int LOSS_W      = 4,
  parameter int IDLE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic              fire,
  input  logic              frame_err,
  input  logic              cdr_lock,
  input  logic              sig_det,
  input  logic              auto_pd,
  input  logic [LOSS_W-1:0] loss_lim,
  output link_state_t       state
);
  localparam int ACQ_W  = $clog2(ACQ_FRAMES + 1);
  localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);

  logic [ACQ_W-1:0]  good_cnt;
  logic [LOSS_W-1:0] bad_cnt;
  logic [IDLE_W-1:0] idle_cnt;
  logic [LOSS_W-1:0] lim_eff;
  logic              idle_hit;
  logic              good_frame;
  logic              bad_frame;
  logic              loss_reached;

  assign lim_eff      = (loss_lim == '0) ? LOSS_W'(1) : loss_lim;
  assign good_frame   = fire && !frame_err && cdr_lock;
  assign bad_frame    = fire && frame_err;
  assign loss_reached = ({1'b0, bad_cnt} + 1'b1) >= {1'b0, lim_eff};
  assign idle_hit     = auto_pd && !sig_det && (state != LS_PD) &&
                        (idle_cnt == IDLE_W'(IDLE_CYCLES - 1));

  // run length of absent stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (!pwr_en || state == LS_PD || sig_det || !auto_pd) begin
      idle_cnt <= '0;
    end else if (idle_cnt != IDLE_W'(IDLE_CYCLES)) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= LS_PD;
      good_cnt <= '0;
      bad_cnt  <= '0;
    end else if (!pwr_en) begin
      state    <= LS_PD;
      good_cnt <= '0;
      bad_cnt  <= '0;
    end else begin
      case (state)
        LS_PD: begin
          good_cnt <= '0;
          bad_cnt  <= '0;
          if (sig_det || !auto_pd) state <= LS_ACQ;
        end
        LS_ACQ: begin
          bad_cnt <= '0;
          if (idle_hit) begin
            state    <= LS_PD;
            good_cnt <= '0;
          end else if (!cdr_lock || bad_frame) begin
            good_cnt <= '0;
          end else if (good_frame) begin
            if (good_cnt == ACQ_W'(ACQ_FRAMES - 1)) begin
              state    <= LS_LOCK;
              good_cnt <= '0;
            end else begin
              good_cnt <= good_cnt + 1'b1;
            end
          end
        end
        LS_LOCK: begin
          good_cnt <= '0;
          if (idle_hit) begin
            state   <= LS_PD;
            bad_cnt <= '0;
          end else if (!cdr_lock) begin
            state   <= LS_ACQ;
            bad_cnt <= '0;
          end else if (bad_frame) begin
            if (loss_reached) begin
              state   <= LS_ACQ;
              bad_cnt <= '0;
            end else begin
              bad_cnt <= bad_cnt + 1'b1;
            end
          end else if (good_frame) begin
            bad_cnt <= '0;
          end
        end
        default: begin
          state    <= LS_PD;
          good_cnt <= '0;
          bad_cnt  <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lro_out_stage.sv
module lro_out_stage #(
  parameter int DATA_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              locked,
  input  logic              fire,
  input  logic [DATA_W-1:0] in_data,
  input  logic              sleep_low,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_oe
);
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (!locked) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= fire;
      if (fire) data_q <= in_data;
    end
  end

  assign out_valid = valid_q & locked;

  for (genvar i = 0; i < DATA_W; i++) begin : g_pin
    assign out_oe[i]   = locked | sleep_low;
    assign out_data[i] = locked & data_q[i];
  end
endmodule

// File: rtl/lro_clk_ctrl.sv
module lro_clk_ctrl
  import lro_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       locked,
  input  logic       auto_clk,
  input  logic       osc_en,
  input  logic       sleep_low,
  input  logic       edge_cfg,
  output logic [1:0] clk_sel,
  output logic       clk_oe,
  output logic       edge_rise
);
  clk_src_t src;

  always_comb begin
    if (locked)                src = CK_PIXEL;
    else if (auto_clk && osc_en) src = CK_OSC;
    else                       src = CK_OFF;
  end

  assign clk_sel = src;
  assign clk_oe  = (src != CK_OFF) | sleep_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       edge_rise <= 1'b0;
    else if (!locked) edge_rise <= edge_cfg;
  end
endmodule

// File: rtl/link_rx_out_ctrl.sv
module link_rx_out_ctrl
  import lro_pkg::*;
#(
  parameter int DATA_W      = 21,
  parameter int ACQ_FRAMES  = 16,
  parameter int LOSS_W      = 4,
  parameter int IDLE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_err,
  output logic              in_ready,
  input  logic              cdr_lock,
  input  logic              sig_det,
  input  logic              osc_en,
  input  logic              cfg_sleep_low,
  input  logic              cfg_auto_clk,
  input  logic              cfg_edge_rise,
  input  logic              cfg_auto_pd,
  input  logic [LOSS_W-1:0] cfg_loss_lim,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_oe,
  output logic [1:0]        clk_sel,
  output logic              clk_oe,
  output logic              out_edge_rise,
  output logic              lock_o
);
  link_state_t state;
  logic        locked;
  logic        fire;

  assign in_ready = (state != LS_PD);
  assign fire     = in_valid & in_ready;
  assign locked   = (state == LS_LOCK);
  assign lock_o   = locked;

  lro_lock_fsm #(
    .ACQ_FRAMES (ACQ_FRAMES),
    .LOSS_W     (LOSS_W),
    .IDLE_CYCLES(IDLE_CYCLES)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_en   (pwr_en),
    .fire     (fire),
    .frame_err(in_err),
    .cdr_lock (cdr_lock),
    .sig_det  (sig_det),
    .auto_pd  (cfg_auto_pd),
    .loss_lim (cfg_loss_lim),
    .state    (state)
  );

  lro_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .locked   (locked),
    .fire     (fire),
    .in_data  (in_data),
    .sleep_low(cfg_sleep_low),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_oe   (out_oe)
  );

  lro_clk_ctrl u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .locked   (locked),
    .auto_clk (cfg_auto_clk),
    .osc_en   (osc_en),
    .sleep_low(cfg_sleep_low),
    .edge_cfg (cfg_edge_rise),
    .clk_sel  (clk_sel),
    .clk_oe   (clk_oe),
    .edge_rise(out_edge_rise)
  );
endmodule

// File: rtl/link_rx_out_ctrl_chk.sv
module link_rx_out_ctrl_chk #(
  parameter int DATA_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_en,
  input logic              cdr_lock,
  input logic              in_ready,
  input logic              cfg_sleep_low,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_oe,
  input logic [DATA_W-1:0] out_data,
  input logic [1:0]        clk_sel,
  input logic              clk_oe,
  input logic              out_edge_rise,
  input logic              lock_o
);
  // R1
  pwrdown_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> (!lock_o && !in_ready));

  // R4
  cdr_loss_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cdr_lock |=> !lock_o);

  // R5
  sleep_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && !cfg_sleep_low) |-> (out_oe == '0 && out_data == '0));

  // R6
  sleep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && cfg_sleep_low) |-> (out_oe == '1 && out_data == '0 && clk_oe));

  // R7
  locked_pixel_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> (clk_sel == 2'b01 && clk_oe && out_oe == '1));

  // R8
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && $past(lock_o)) |-> $stable(out_edge_rise));

  // R9
  first_word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> !out_valid);

  // R9
  valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> lock_o);

  // R12
  ready_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> in_ready);
endmodule

bind link_rx_out_ctrl link_rx_out_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_en       (pwr_en),
  .cdr_lock     (cdr_lock),
  .in_ready     (in_ready),
  .cfg_sleep_low(cfg_sleep_low),
  .out_valid    (out_valid),
  .out_oe       (out_oe),
  .out_data     (out_data),
  .clk_sel      (clk_sel),
  .clk_oe       (clk_oe),
  .out_edge_rise(out_edge_rise),
  .lock_o       (lock_o)
);

// File: tb/link_rx_out_ctrl_bench.sv
`timescale 1ns/1ps
module link_rx_out_ctrl_bench;
  localparam int DW   = 21;
  localparam int LW   = 4;
  localparam int IDLE = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_en = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_err = 1'b0;
  logic          in_ready;
  logic          cdr_lock = 1'b0;
  logic          sig_det = 1'b0;
  logic          osc_en = 1'b0;
  logic          cfg_sleep_low = 1'b0;
  logic          cfg_auto_clk = 1'b0;
  logic          cfg_edge_rise = 1'b0;
  logic          cfg_auto_pd = 1'b0;
  logic [LW-1:0] cfg_loss_lim = 4'd3;
  logic [DW-1:0] out_data;
  logic          out_valid;
  logic [DW-1:0] out_oe;
  logic [1:0]    clk_sel;
  logic          clk_oe;
  logic          out_edge_rise;
  logic          lock_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  link_rx_out_ctrl #(.DATA_W(DW), .LOSS_W(LW), .IDLE_CYCLES(IDLE)) u_link_rx_out_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .in_data(in_data),
    .in_valid(in_valid), .in_err(in_err), .in_ready(in_ready),
    .cdr_lock(cdr_lock), .sig_det(sig_det), .osc_en(osc_en),
    .cfg_sleep_low(cfg_sleep_low), .cfg_auto_clk(cfg_auto_clk),
    .cfg_edge_rise(cfg_edge_rise), .cfg_auto_pd(cfg_auto_pd),
    .cfg_loss_lim(cfg_loss_lim), .out_data(out_data), .out_valid(out_valid),
    .out_oe(out_oe), .clk_sel(clk_sel), .clk_oe(clk_oe),
    .out_edge_rise(out_edge_rise), .lock_o(lock_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic frame(input bit good, input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_err   = !good;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    in_err   = 1'b0;
  endtask

  task automatic goods(input int n);
    for (int i = 0; i < n; i++) frame(1'b1, DW'(i + 1));
  endtask

  task automatic relock();
    goods(16);
  endtask

  task automatic t_reset();
    step(2);
    chk("R1 lock in reset", {31'd0, lock_o}, 32'd0);
    chk("R1 ready in reset", {31'd0, in_ready}, 32'd0);
    chk("R5 oe hiz", 32'(out_oe), 32'd0);
    chk("R5 clk_oe", {31'd0, clk_oe}, 32'd0);
    chk("R7 clk off", {30'd0, clk_sel}, 32'd0);
  endtask

  task automatic t_acquire();
    pwr_en = 1'b1; sig_det = 1'b1; cdr_lock = 1'b1;
    step(1);
    chk("R12 ready after power-up", {31'd0, in_ready}, 32'd1);
    goods(15);
    frame(1'b0, '0);
    chk("R2 bad frame restarts", {31'd0, lock_o}, 32'd0);
    goods(15);
    chk("R2 15 goods not enough", {31'd0, lock_o}, 32'd0);
    goods(1);
    chk("R2 lock after 16", {31'd0, lock_o}, 32'd1);
    chk("R9 lock frame not shown", {31'd0, out_valid}, 32'd0);
    chk("R7 pixel clock", {30'd0, clk_sel}, 32'd1);
    chk("R12 ready locked", {31'd0, in_ready}, 32'd1);
    frame(1'b1, 21'h15A5A5);
    chk("R9 first word valid", {31'd0, out_valid}, 32'd1);
    chk("R9 first word data", 32'(out_data), 32'h15A5A5);
    step(1);
    chk("R9 valid one cycle", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_loss();
    cfg_loss_lim = 4'd3;
    frame(1'b0, '0); frame(1'b0, '0); frame(1'b1, 21'h3);
    frame(1'b0, '0); frame(1'b0, '0);
    chk("R3 run cleared by good", {31'd0, lock_o}, 32'd1);
    frame(1'b0, '0);
    chk("R3 lost at limit", {31'd0, lock_o}, 32'd0);
    chk("R5 data zero unlocked", 32'(out_data), 32'd0);
    relock();
    cfg_loss_lim = 4'd0;
    frame(1'b0, '0);
    chk("R3 limit zero acts as one", {31'd0, lock_o}, 32'd0);
    cfg_loss_lim = 4'd3;
  endtask

  task automatic t_cdr();
    relock();
    @(negedge clk); cdr_lock = 1'b0;
    @(negedge clk);
    chk("R4 cdr loss", {31'd0, lock_o}, 32'd0);
    cdr_lock = 1'b1;
  endtask

  task automatic t_sleep_clk();
    cfg_sleep_low = 1'b1;
    step(1);
    chk("R6 oe driven", 32'(out_oe), 32'h1FFFFF);
    chk("R6 clk_oe", {31'd0, clk_oe}, 32'd1);
    chk("R6 clk held low", {30'd0, clk_sel}, 32'd0);
    cfg_sleep_low = 1'b0; cfg_auto_clk = 1'b1; osc_en = 1'b1;
    step(1);
    chk("R7 oscillator", {30'd0, clk_sel}, 32'd2);
    chk("R7 osc clk_oe", {31'd0, clk_oe}, 32'd1);
    osc_en = 1'b0;
    step(1);
    chk("R7 no osc", {30'd0, clk_sel}, 32'd0);
    chk("R5 clk_oe off", {31'd0, clk_oe}, 32'd0);
    cfg_auto_clk = 1'b0; osc_en = 1'b1;
    step(1);
    chk("R7 auto-clock off", {30'd0, clk_sel}, 32'd0);
    osc_en = 1'b0;
  endtask

  task automatic t_edge();
    cfg_edge_rise = 1'b1;
    step(1);
    chk("R8 follows unlocked", {31'd0, out_edge_rise}, 32'd1);
    relock();
    cfg_edge_rise = 1'b0;
    step(3);
    chk("R8 held while locked", {31'd0, out_edge_rise}, 32'd1);
    @(negedge clk); cdr_lock = 1'b0;
    @(negedge clk); cdr_lock = 1'b1;
    step(1);
    chk("R8 updates after unlock", {31'd0, out_edge_rise}, 32'd0);
  endtask

  task automatic t_autopd();
    relock();
    cfg_auto_pd = 1'b1;
    @(negedge clk); sig_det = 1'b0;
    step(IDLE - 1);
    chk("R10 still locked before limit", {31'd0, lock_o}, 32'd1);
    step(1);
    chk("R10 powered down lock", {31'd0, lock_o}, 32'd0);
    chk("R10 powered down ready", {31'd0, in_ready}, 32'd0);
    goods(16);
    chk("R10 frames ignored", {31'd0, lock_o}, 32'd0);
    sig_det = 1'b1;
    step(1);
    chk("R10 ready on return", {31'd0, in_ready}, 32'd1);
    relock();
    chk("R10 relock", {31'd0, lock_o}, 32'd1);
  endtask

  task automatic t_no_autopd();
    cfg_auto_pd = 1'b0;
    @(negedge clk); sig_det = 1'b0;
    step(IDLE + 10);
    chk("R11 sig_det ignored", {31'd0, lock_o}, 32'd1);
    sig_det = 1'b1;
  endtask

  task automatic t_pwr();
    @(negedge clk); pwr_en = 1'b0;
    @(negedge clk);
    chk("R1 power-down lock", {31'd0, lock_o}, 32'd0);
    chk("R1 power-down ready", {31'd0, in_ready}, 32'd0);
    chk("R1 sleep oe", 32'(out_oe), 32'd0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    t_reset();
    t_acquire();
    t_loss();
    t_cdr();
    t_sleep_clk();
    t_edge();
    t_autopd();
    t_no_autopd();
    t_pwr();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule